// File: doc/BRIEF.md
# Prescaled 16-bit Mode Timer Counter

This block is a 16-bit counter that moves one step each time a prescaler, fed by an external tick-enable input, reaches its selected division ratio. The counter can run freely over the whole 16-bit range, wrap at a programmable period, or bounce between zero and that period for centre-aligned waveforms. A 2-bit mode field starts it, and writing zero to that field stops it where it is.

Software reaches the block through a small 8-bit register port. A read of the count low byte copies the count high byte into a holding register, so a following read of the high address returns a value that belongs with the low byte already read. Any write to the count low address clears the count. When the count reaches its terminal value, a sticky overflow flag is set. An interrupt line follows that flag, gated by a mask bit and a global enable bit.

Top module: `mode_timer16`

## Requirements
- R1: After reset the count reads 0x0000, the control register reads 0x00 (mode 00, halted), and both the overflow flag and the interrupt output are 0.
- R2: Control bits [3:2] select the prescale ratio: 00 gives one count step per tick, 01 one per 8 ticks, 10 one per 32 ticks, 11 one per 128 ticks. Ticks are counted only while the counter runs.
- R3: In free-running mode (control bits [1:0] = 01) the count goes up by one per step and wraps from 0xFFFF to 0x0000.
- R4: The overflow flag (control bit 7 and output ovfFlag) is set on the step where the count becomes 0xFFFF in free-running mode.
- R5: In modulo mode (bits [1:0] = 10) the count goes up from 0 to the period register value, sets the overflow flag on the step that reaches the period, and returns to 0 on the next step.
- R6: In up/down mode (bits [1:0] = 11) the count goes up to the period value, then down to 0, and sets the overflow flag on the step that reaches 0.
- R7: The overflow flag stays set until a control write with bit 7 = 0. A control write with bit 7 = 1 leaves the flag unchanged. An overflow in the same cycle as a clearing write keeps the flag set.
- R8: irqOut is 1 exactly when the overflow flag, the mask bit (control bit 4) and the global enable bit (control bit 5) are all 1.
- R9: A read of address 0 (count low byte) copies the count high byte of that cycle into a holding register. A read of address 1 returns the holding register, not the live high byte.
- R10: Any write to address 0 clears the 16-bit count, the prescaler and the up/down direction, whatever data is written.
- R11: Mode 00 halts the count at its present value. Any nonzero mode restarts it from that value, and the prescaler restarts from zero when halted.
- R12: The address map is 0 count low, 1 held count high, 2 control, 3 period low, 4 period high. Reads return register contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | Tick enable feeding the prescaler |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (needed for the snapshot side effect) |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr |
| ovfFlag | output | 1 | Sticky overflow flag |
| irqOut | output | 1 | Masked interrupt request |

## Verification
On every cycle, the embedded assertions check the following: a clear leaves a zero count, a halted count never moves, a free-running count wraps at all-ones, the holding register takes the high byte at a low-byte read, an overflow event always leaves the flag set, and after a step the prescaler cannot step again at once unless the ratio is 1. The ratio values, the modulo and up/down sequences, and the period-driven turning points can only be shown by the bench's directed scenarios, which count ticks and compare the read-back counts. The same holds for the order of the clear-write and overflow priority, the three-input interrupt gating, and the case where the held high byte differs from the live one.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_FREE = 2'b01,
    MODE_MOD  = 2'b10,
    MODE_UPDN = 2'b11
  } cntMode_e;

  localparam logic [2:0] ADR_CNT_LO = 3'd0;
  localparam logic [2:0] ADR_CNT_HI = 3'd1;
  localparam logic [2:0] ADR_CTRL   = 3'd2;
  localparam logic [2:0] ADR_PER_LO = 3'd3;
  localparam logic [2:0] ADR_PER_HI = 3'd4;

  // control -> datapath strobes
  typedef struct packed {
    logic     step;
    logic     clear;
    logic     snap;
    cntMode_e mode;
  } tmrStrobe_t;

endpackage

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 7,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] hiHold,
  input  logic              ovfEvent,
  output tmrStrobe_t        strobe,
  output logic [CNT_W-1:0]  period,
  output logic              ovfFlag,
  output logic              irqOut
);

  cntMode_e         mode;
  logic [1:0]       divSel;
  logic             ovfMask;
  logic             globalEn;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             preAtLimit;
  logic             ctrlWr;
  logic             flagClr;
  logic [2:0]       preShift;

  assign ctrlWr  = busWrEn && (busAddr == ADDR_W'(ADR_CTRL));
  assign flagClr = ctrlWr && !busWrData[DATA_W-1];

  // ratio 1, 8, 32, 128 -> shift 0, 3, 5, 7
  assign preShift   = (divSel == 2'd0) ? 3'd0 : 3'({divSel, 1'b1});
  assign preLimit   = PRE_W'((1 << preShift) - 1);
  assign preAtLimit = (preCnt >= preLimit);

  assign strobe.clear = busWrEn && (busAddr == ADDR_W'(ADR_CNT_LO));
  assign strobe.snap  = busRdEn && (busAddr == ADDR_W'(ADR_CNT_LO));
  assign strobe.mode  = mode;
  assign strobe.step  = tickIn && (mode != MODE_HALT) && preAtLimit && !strobe.clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_HALT;
      divSel   <= 2'd0;
      ovfMask  <= 1'b0;
      globalEn <= 1'b0;
    end else if (ctrlWr) begin
      mode     <= cntMode_e'(busWrData[1:0]);
      divSel   <= busWrData[3:2];
      ovfMask  <= busWrData[4];
      globalEn <= busWrData[5];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period <= '0;
    end else if (busWrEn && busAddr == ADDR_W'(ADR_PER_LO)) begin
      period[DATA_W-1:0] <= busWrData;
    end else if (busWrEn && busAddr == ADDR_W'(ADR_PER_HI)) begin
      period[CNT_W-1:DATA_W] <= busWrData;
    end
  end

  // prescaler restarts on clear and while halted
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobe.clear || mode == MODE_HALT) begin
      preCnt <= '0;
    end else if (tickIn) begin
      preCnt <= preAtLimit ? '0 : preCnt + 1'b1;
    end
  end

  // sticky flag: a new event beats a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (ovfEvent) begin
      ovfFlag <= 1'b1;
    end else if (flagClr) begin
      ovfFlag <= 1'b0;
    end
  end

  assign irqOut = ovfFlag && ovfMask && globalEn;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(ADR_CNT_LO): busRdData = count[DATA_W-1:0];
      ADDR_W'(ADR_CNT_HI): busRdData = hiHold;
      ADDR_W'(ADR_CTRL):   busRdData = DATA_W'({ovfFlag, 1'b0, globalEn, ovfMask, divSel, mode});
      ADDR_W'(ADR_PER_LO): busRdData = period[DATA_W-1:0];
      ADDR_W'(ADR_PER_HI): busRdData = period[CNT_W-1:DATA_W];
      default:             busRdData = '0;
    endcase
  end

  // R4 / R5 / R6: any overflow event leaves the flag set
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> ovfFlag);

  // R7: flag only drops through a clearing control write
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);

  // R2: after a step the prescaler restarts, so no back-to-back steps above ratio 1
  p_prescale_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && preLimit != '0 && !ctrlWr) |=> !strobe.step);

endmodule

// File: rtl/tmr16_datapath.sv
module tmr16_datapath
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] hiHold,
  output logic              ovfEvent
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic             dirUp;
  logic             dirNext;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] cntDec;

  assign cntInc = count + 1'b1;
  assign cntDec = count - 1'b1;

  always_comb begin
    cntNext  = count;
    dirNext  = dirUp;
    ovfEvent = 1'b0;
    if (strobe.clear) begin
      cntNext = '0;
      dirNext = 1'b1;
    end else if (strobe.step) begin
      case (strobe.mode)
        MODE_FREE: begin
          cntNext  = cntInc;
          ovfEvent = (cntInc == ALL_ONES);
        end
        MODE_MOD: begin
          if (count >= period) begin
            cntNext = '0;
          end else begin
            cntNext  = cntInc;
            ovfEvent = (cntInc == period);
          end
        end
        MODE_UPDN: begin
          if (dirUp) begin
            if (count >= period) begin
              dirNext  = 1'b0;
              cntNext  = (count == '0) ? '0 : cntDec;
              ovfEvent = (count == CNT_W'(1));
            end else begin
              cntNext = cntInc;
            end
          end else begin
            if (count <= CNT_W'(1)) begin
              cntNext  = '0;
              dirNext  = 1'b1;
              ovfEvent = (count == CNT_W'(1));
            end else begin
              cntNext = cntDec;
            end
          end
        end
        default: cntNext = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      dirUp <= 1'b1;
    end else begin
      count <= cntNext;
      dirUp <= dirNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiHold <= '0;
    end else if (strobe.snap) begin
      hiHold <= count[CNT_W-1:DATA_W];
    end
  end

  // R10: a clear always leaves a zero count
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0));

  // R11: a halted counter holds its value
  p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == MODE_HALT && !strobe.clear) |=> $stable(count));

  // R3: free-running wrap from all-ones to zero
  p_free_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.clear && strobe.mode == MODE_FREE && count == ALL_ONES)
      |=> (count == '0));

  // R9: low-byte read captures the high byte of that cycle
  p_snap_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snap |=> (hiHold == $past(count[CNT_W-1:DATA_W])));

endmodule

// File: rtl/mode_timer16.sv
module mode_timer16
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int PRE_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              ovfFlag,
  output logic              irqOut
);

  localparam int CNT_W = 2 * DATA_W;

  tmrStrobe_t        strobe;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] hiHold;
  logic              ovfEvent;

  tmr16_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .count(count), .hiHold(hiHold), .ovfEvent(ovfEvent),
    .strobe(strobe), .period(period), .ovfFlag(ovfFlag), .irqOut(irqOut)
  );

  tmr16_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .period(period),
    .count(count), .hiHold(hiHold), .ovfEvent(ovfEvent)
  );

endmodule

// File: tb/mode_timer16_bench.sv
module mode_timer16_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       ovfFlag;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mode_timer16 u_mode_timer16 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .ovfFlag(ovfFlag), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rdCount(output int v);
    logic [7:0] lo, hi;
    rd(3'd0, lo);
    rd(3'd1, hi);
    v = {hi, lo};
  endtask

  // control byte: bit7 keep-flag, bit5 enable, bit4 mask, [3:2] ratio, [1:0] mode
  task automatic setCtrl(input logic [1:0] m, input logic [1:0] dv,
                         input bit msk, input bit en, input bit keep);
    wr(3'd2, {keep, 1'b0, en, msk, dv, m});
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tickIn = 1'b1;
      repeat (n) @(negedge clk);
      tickIn = 1'b0;
    end
  endtask

  task automatic setPeriod(input int p);
    wr(3'd3, p[7:0]);
    wr(3'd4, p[15:8]);
  endtask

  task automatic testReset();
    logic [7:0] c;
    int v;
    rd(3'd2, c);
    check(c == 8'h00, "R1 control", c, 0);
    rdCount(v);
    check(v == 0, "R1 count", v, 0);
    check(ovfFlag == 1'b0 && irqOut == 1'b0, "R1 flag/irq", {ovfFlag, irqOut}, 0);
  endtask

  task automatic testClearSnap();
    logic [7:0] d;
    int v;
    setCtrl(2'b01, 2'b00, 0, 0, 1);
    wr(3'd0, 8'h00);
    ticks(255);
    rdCount(v);
    check(v == 16'h00FF, "R3 count up", v, 16'h00FF);
    rd(3'd0, d);             // snapshot high byte 0x00
    ticks(1);                // live count now 0x0100
    rd(3'd1, d);
    check(d == 8'h00, "R9 held high byte", d, 0);
    rdCount(v);
    check(v == 16'h0100, "R9 fresh snapshot", v, 16'h0100);
    wr(3'd0, 8'hA5);
    rdCount(v);
    check(v == 0, "R10 low write clears", v, 0);
  endtask

  task automatic testPrescale();
    int v;
    setCtrl(2'b01, 2'b01, 0, 0, 1);
    wr(3'd0, 8'h00);
    ticks(16);
    rdCount(v);
    check(v == 2, "R2 ratio 8", v, 2);
    ticks(7);
    rdCount(v);
    check(v == 2, "R2 ratio 8 partial", v, 2);
    ticks(1);
    rdCount(v);
    check(v == 3, "R2 ratio 8 boundary", v, 3);
    ticks(5);
    wr(3'd0, 8'h00);         // R10: prescaler restarts too
    ticks(7);
    rdCount(v);
    check(v == 0, "R10 prescaler cleared", v, 0);
    ticks(1);
    rdCount(v);
    check(v == 1, "R10 prescaler restart", v, 1);
    setCtrl(2'b01, 2'b10, 0, 0, 1);
    wr(3'd0, 8'h00);
    ticks(64);
    rdCount(v);
    check(v == 2, "R2 ratio 32", v, 2);
    setCtrl(2'b01, 2'b11, 0, 0, 1);
    wr(3'd0, 8'h00);
    ticks(127);
    rdCount(v);
    check(v == 0, "R2 ratio 128 partial", v, 0);
    ticks(1);
    rdCount(v);
    check(v == 1, "R2 ratio 128", v, 1);
  endtask

  task automatic testHalt();
    int v;
    setCtrl(2'b01, 2'b00, 0, 0, 1);
    wr(3'd0, 8'h00);
    ticks(5);
    setCtrl(2'b00, 2'b00, 0, 0, 1);
    ticks(10);
    rdCount(v);
    check(v == 5, "R11 halted holds", v, 5);
    setCtrl(2'b01, 2'b00, 0, 0, 1);
    ticks(3);
    rdCount(v);
    check(v == 8, "R11 resume", v, 8);
    // prescaler restarts on halt
    setCtrl(2'b01, 2'b01, 0, 0, 1);
    ticks(5);
    setCtrl(2'b00, 2'b01, 0, 0, 1);
    setCtrl(2'b01, 2'b01, 0, 0, 1);
    ticks(7);
    rdCount(v);
    check(v == 8, "R11 prescaler reset on halt", v, 8);
  endtask

  task automatic testModulo();
    int v;
    setCtrl(2'b10, 2'b00, 0, 0, 0);   // clear flag
    setPeriod(5);
    wr(3'd0, 8'h00);
    ticks(4);
    check(ovfFlag == 1'b0, "R5 no flag before period", ovfFlag, 0);
    ticks(1);
    rdCount(v);
    check(v == 5 && ovfFlag, "R5 reach period", v, 5);
    ticks(1);
    rdCount(v);
    check(v == 0, "R5 wrap to zero", v, 0);
  endtask

  task automatic testUpDown();
    int v;
    setCtrl(2'b11, 2'b00, 0, 0, 0);
    setPeriod(3);
    wr(3'd0, 8'h00);
    ticks(3);
    rdCount(v);
    check(v == 3, "R6 top", v, 3);
    ticks(2);
    rdCount(v);
    check(v == 1 && !ovfFlag, "R6 descending", v, 1);
    ticks(1);
    rdCount(v);
    check(v == 0 && ovfFlag, "R6 reach zero flag", {ovfFlag, v[15:0]}, 17'h10000);
    ticks(1);
    rdCount(v);
    check(v == 1, "R6 turn up", v, 1);
  endtask

  task automatic testFlagPriority();
    int v;
    setCtrl(2'b10, 2'b00, 0, 0, 1);
    setPeriod(2);
    wr(3'd0, 8'h00);
    ticks(1);
    check(ovfFlag == 1'b1, "R7 flag still set", ovfFlag, 1);
    @(negedge clk);
    busAddr = 3'd2; busWrData = 8'h02; busWrEn = 1'b1; tickIn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; tickIn = 1'b0;
    rdCount(v);
    check(v == 2 && ovfFlag, "R7 event beats clear", {ovfFlag, v[15:0]}, 17'h10002);
    setCtrl(2'b10, 2'b00, 0, 0, 1);
    check(ovfFlag == 1'b1, "R7 write one keeps", ovfFlag, 1);
    setCtrl(2'b10, 2'b00, 0, 0, 0);
    check(ovfFlag == 1'b0, "R7 write zero clears", ovfFlag, 0);
    setCtrl(2'b10, 2'b00, 0, 0, 1);
    check(ovfFlag == 1'b0, "R7 write one no set", ovfFlag, 0);
  endtask

  task automatic testIrq();
    setCtrl(2'b00, 2'b00, 1, 1, 1);
    check(irqOut == 1'b0, "R8 no flag no irq", irqOut, 0);
    setPeriod(1);
    setCtrl(2'b10, 2'b00, 0, 1, 1);
    wr(3'd0, 8'h00);
    ticks(1);
    check(ovfFlag && !irqOut, "R8 masked", irqOut, 0);
    setCtrl(2'b10, 2'b00, 1, 0, 1);
    check(!irqOut, "R8 globally disabled", irqOut, 0);
    setCtrl(2'b10, 2'b00, 1, 1, 1);
    check(irqOut == 1'b1, "R8 all set", irqOut, 1);
    setCtrl(2'b10, 2'b00, 1, 1, 0);
    check(irqOut == 1'b0, "R8 follows flag clear", irqOut, 0);
  endtask

  task automatic testFreeWrap();
    int v;
    setCtrl(2'b01, 2'b00, 0, 0, 0);
    wr(3'd0, 8'h00);
    ticks(65534);
    rdCount(v);
    check(v == 16'hFFFE && !ovfFlag, "R4 before terminal", v, 16'hFFFE);
    ticks(1);
    rdCount(v);
    check(v == 16'hFFFF && ovfFlag, "R4 terminal sets flag", v, 16'hFFFF);
    ticks(1);
    rdCount(v);
    check(v == 0, "R3 wrap to zero", v, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testClearSnap();
    testPrescale();
    testHalt();
    testModulo();
    testUpDown();
    testFlagPriority();
    testIrq();
    testFreeWrap();
    // R12: period registers read back at their addresses
    begin
      logic [7:0] a, b;
      setPeriod(16'h3C5A);
      rd(3'd3, a);
      rd(3'd4, b);
      check({b, a} == 16'h3C5A, "R12 period map", {b, a}, 16'h3C5A);
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule